// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects interrupt events from four DMA channels and turns them into prioritized interrupt requests. Each channel has two request sources. The completion source fires when the channel's transfer counter runs out. The escape source fires when a transfer ends before the counter reaches zero. Four separate abnormal-termination events can raise the escape source: a transfer size error, the end of a repeat block, an overflow of the extended repeat area on the source address, and the same overflow on the destination address. All four are merged into one escape flag per channel, and the request does not record which cause set it.

Each source has a sticky status flag and an enable bit. A request is asserted while the flag and the enable are both 1. The block drives eight request lines and, for the interrupt controller, an encoded index of the highest-priority active request with a valid bit. The four completion requests always rank above the four escape requests. Within each group, the lower channel number wins. Software reaches the flags and the enables through a small register port. A write with a 0 in a flag bit clears that flag.

Top module: `dma_irq_agg`

## Requirements
- R1: A 1 on `done_evt_i[k]` at a clock edge sets the completion flag of channel k, which is flags bit k. The flag stays set after the event goes away.
- R2: A 1 on any of `size_err_i[k]`, `rpt_end_i[k]`, `src_ovf_i[k]` or `dst_ovf_i[k]` at a clock edge sets the escape flag of channel k, which is flags bit 4+k. All four causes give the same result.
- R3: `irq_req_o[i]` equals flags bit i AND enable bit i. Bits 3..0 are the completion requests of channels 3..0, and bits 7..4 are the escape requests of channels 3..0.
- R4: A write to address 0 (flags) clears every flag whose `reg_wdata_i` bit is 0. Flags whose data bit is 1 are left unchanged.
- R5: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Address 1 holds the enables, with the same bit layout as the flags, and is read/write. Clearing an enable bit masks its request at once but keeps the flag. Setting the bit again raises the request again.
- R7: `irq_vec_o` gives the lowest index i with `irq_req_o[i]` = 1. The order is therefore completion ch0, ch1, ch2, ch3, then escape ch0, ch1, ch2, ch3. It is 0 when no request is active.
- R8: `irq_valid_o` is 1 exactly when at least one request bit is 1.
- R9: A synchronous active-high `rst` clears all flags and all enables.
- R10: `reg_rdata_o` shows the flags when `reg_addr_i` is 0 and the enables when it is 1, in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| done_evt_i | input | 4 | Per-channel event: transfer counter reached zero |
| size_err_i | input | 4 | Per-channel escape cause: transfer size error |
| rpt_end_i | input | 4 | Per-channel escape cause: repeat block finished |
| src_ovf_i | input | 4 | Per-channel escape cause: source extended repeat area overflow |
| dst_ovf_i | input | 4 | Per-channel escape cause: destination extended repeat area overflow |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data of the selected register |
| irq_req_o | output | 8 | Request lines: flag AND enable |
| irq_vec_o | output | 3 | Index of the highest-priority active request |
| irq_valid_o | output | 1 | Any request active |

## Verification
The main function is driven with a table of event patterns. The table covers a single completion, a single escape from each kind of cause, and a completion and an escape together, so it can tell whether completions outrank escapes. It also covers several escapes at once, so it can tell whether the lower channel wins. Some patterns use partial enable masks, which separate a flag from its request. One pattern fires all four causes on one channel, to show that they merge into one flag bit. Directed tests then cover the following:
- A partial write-0 clear, and a write of all ones that changes nothing.
- A set and a clear hitting the same flag in one cycle.
- Masking a request and enabling it again.
- A reset in the middle of a run.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;
    typedef enum logic {
        SEL_FLAGS   = 1'b0,
        SEL_ENABLES = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/dma_irq_flag.sv
// One sticky status bit: set wins over clear.
module dma_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/dma_irq_regport.sv
// Register decode: write-0-to-clear flags, read/write enables, read mux.
module dma_irq_regport
    import dma_irq_agg_pkg::*;
#(
    parameter int REQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [REQ_W-1:0] wdata_i,
    input  logic [REQ_W-1:0] flags_i,
    output logic [REQ_W-1:0] clr_o,
    output logic [REQ_W-1:0] en_o,
    output logic [REQ_W-1:0] rdata_o
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr_i);

    assign clr_o = (wr_i && sel == SEL_FLAGS) ? ~wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst)
            en_o <= '0;
        else if (wr_i && sel == SEL_ENABLES)
            en_o <= wdata_i;
    end

    always_comb begin
        unique case (sel)
            SEL_FLAGS:   rdata_o = flags_i;
            SEL_ENABLES: rdata_o = en_o;
            default:     rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dma_irq_prio.sv
// Fixed priority encoder: lowest set index wins.
module dma_irq_prio #(
    parameter int REQ_W = 8,
    parameter int VEC_W = $clog2(REQ_W)
) (
    input  logic [REQ_W-1:0] req_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             valid_o
);
    always_comb begin
        vec_o = '0;
        for (int i = REQ_W - 1; i >= 0; i--) begin
            if (req_i[i])
                vec_o = VEC_W'(i);
        end
    end

    assign valid_o = |req_i;
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
    parameter int NUM_CH = 4,
    localparam int REQ_W = 2 * NUM_CH,
    localparam int VEC_W = $clog2(REQ_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] done_evt_i,
    input  logic [NUM_CH-1:0] size_err_i,
    input  logic [NUM_CH-1:0] rpt_end_i,
    input  logic [NUM_CH-1:0] src_ovf_i,
    input  logic [NUM_CH-1:0] dst_ovf_i,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [REQ_W-1:0]  reg_wdata_i,
    output logic [REQ_W-1:0]  reg_rdata_o,
    output logic [REQ_W-1:0]  irq_req_o,
    output logic [VEC_W-1:0]  irq_vec_o,
    output logic              irq_valid_o
);
    logic [NUM_CH-1:0] esc_evt;
    logic [REQ_W-1:0]  set_vec;
    logic [REQ_W-1:0]  clr_vec;
    logic [REQ_W-1:0]  flags_q;
    logic [REQ_W-1:0]  en_q;

    // Escape causes are merged per channel; the cause is not kept.
    assign esc_evt = size_err_i | rpt_end_i | src_ovf_i | dst_ovf_i;
    assign set_vec = {esc_evt, done_evt_i};

    for (genvar g = 0; g < REQ_W; g++) begin : g_flag
        dma_irq_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_vec[g]),
            .clr_i  (clr_vec[g]),
            .flag_o (flags_q[g])
        );
    end

    dma_irq_regport #(.REQ_W(REQ_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .flags_i (flags_q),
        .clr_o   (clr_vec),
        .en_o    (en_q),
        .rdata_o (reg_rdata_o)
    );

    assign irq_req_o = flags_q & en_q;

    dma_irq_prio #(.REQ_W(REQ_W), .VEC_W(VEC_W)) u_prio (
        .req_i   (irq_req_o),
        .vec_o   (irq_vec_o),
        .valid_o (irq_valid_o)
    );
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
    parameter int NUM_CH = 4,
    localparam int REQ_W = 2 * NUM_CH,
    localparam int VEC_W = $clog2(REQ_W)
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] done_evt,
    input logic [NUM_CH-1:0] size_err,
    input logic [NUM_CH-1:0] rpt_end,
    input logic [NUM_CH-1:0] src_ovf,
    input logic [NUM_CH-1:0] dst_ovf,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [REQ_W-1:0]  reg_wdata,
    input logic [REQ_W-1:0]  flags,
    input logic [REQ_W-1:0]  en,
    input logic [REQ_W-1:0]  irq_req,
    input logic [VEC_W-1:0]  irq_vec,
    input logic              irq_valid
);
    logic [REQ_W-1:0] set_any;
    assign set_any = {size_err | rpt_end | src_ovf | dst_ovf, done_evt};

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (set_any != '0) |=> ((flags & $past(set_any)) == $past(set_any))); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == 1'b0) |=> ((flags & $past(flags)) == $past(flags))); // R1

    AST_W0_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 1'b0) |=> ((flags & ~$past(set_any) & ~$past(reg_wdata)) == '0)); // R4

    AST_REQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        ((irq_req & ~en) == '0)); // R6

    AST_VALID_ANY: assert property (@(posedge clk) disable iff (rst)
        (irq_valid == (irq_req != '0))); // R8

    AST_VEC_TOP: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_req[irq_vec] &&
            ((irq_req & ((REQ_W'(1) << irq_vec) - REQ_W'(1))) == '0))); // R7
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .done_evt  (done_evt_i),
    .size_err  (size_err_i),
    .rpt_end   (rpt_end_i),
    .src_ovf   (src_ovf_i),
    .dst_ovf   (dst_ovf_i),
    .reg_wr    (reg_wr_i),
    .reg_addr  (reg_addr_i),
    .reg_wdata (reg_wdata_i),
    .flags     (flags_q),
    .en        (en_q),
    .irq_req   (irq_req_o),
    .irq_vec   (irq_vec_o),
    .irq_valid (irq_valid_o)
);

// File: tb/dma_irq_agg_test.sv
`timescale 1ns/1ps
module dma_irq_agg_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] done_evt = '0, size_err = '0, rpt_end = '0, src_ovf = '0, dst_ovf = '0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, irq_req;
    logic [2:0] irq_vec;
    logic       irq_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    dma_irq_agg uut (
        .clk(clk), .rst(rst),
        .done_evt_i(done_evt), .size_err_i(size_err), .rpt_end_i(rpt_end),
        .src_ovf_i(src_ovf), .dst_ovf_i(dst_ovf),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_req_o(irq_req),
        .irq_vec_o(irq_vec), .irq_valid_o(irq_valid)
    );

    // en, done, size, rpt, src, dst, exp flags, exp req, exp vec, exp valid
    localparam int NV = 8;
    localparam logic [47:0] VECS [NV] = '{
        {8'hFF, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 8'h01, 8'h01, 3'd0, 1'b1},
        {8'hFF, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 8'h08, 8'h08, 3'd3, 1'b1},
        {8'hFF, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 8'h40, 8'h40, 3'd6, 1'b1},
        {8'hFF, 4'b0100, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 8'h14, 8'h14, 3'd2, 1'b1},
        {8'hF0, 4'b1111, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 8'h2F, 8'h20, 3'd5, 1'b1},
        {8'h0F, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 8'h80, 8'h00, 3'd0, 1'b0},
        {8'hFF, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'b1000, 8'hC0, 8'hC0, 3'd6, 1'b1},
        {8'h80, 4'b1000, 4'b1000, 4'b1000, 4'b1000, 4'b1000, 8'h88, 8'h80, 3'd7, 1'b1}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        tick(); tick();
        rst = 1'b0;
        // Reset state
        rd(1'b0, r); chk("R9 flags after reset", r, 8'h00);
        rd(1'b1, r); chk("R9 enables after reset", r, 8'h00);
        chk("R8 valid after reset", {7'd0, irq_valid}, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VECS[i];
            wr(1'b0, 8'h00);
            wr(1'b1, v[47:40]);
            done_evt = v[39:36]; size_err = v[35:32]; rpt_end = v[31:28];
            src_ovf = v[27:24]; dst_ovf = v[23:20];
            tick();
            done_evt = '0; size_err = '0; rpt_end = '0; src_ovf = '0; dst_ovf = '0;
            rd(1'b0, r);
            chk($sformatf("R1/R2 flags vec%0d", i), r, v[19:12]);
            chk($sformatf("R3 req vec%0d", i), irq_req, v[11:4]);
            chk($sformatf("R7 vector vec%0d", i), {5'd0, irq_vec}, {5'd0, v[3:1]});
            chk($sformatf("R8 valid vec%0d", i), {7'd0, irq_valid}, {7'd0, v[0]});
        end

        // R10 enable readback
        wr(1'b1, 8'hA5);
        rd(1'b1, r); chk("R10 enable readback", r, 8'hA5);

        // R1 sticky over several cycles
        wr(1'b0, 8'h00);
        wr(1'b1, 8'hFF);
        done_evt = 4'b0001; size_err = 4'b0001;
        tick();
        done_evt = '0; size_err = '0;
        tick(); tick(); tick();
        rd(1'b0, r); chk("R1 flags held", r, 8'h11);
        chk("R7 ch0 completion first", {5'd0, irq_vec}, 8'h00);

        // R4 partial clear, then write all ones
        wr(1'b0, 8'hF0);
        rd(1'b0, r); chk("R4 partial clear", r, 8'h10);
        chk("R7 escape ch0 after clear", {5'd0, irq_vec}, 8'h04);
        wr(1'b0, 8'hFF);
        rd(1'b0, r); chk("R4 ones keep flags", r, 8'h10);

        // R5 set and clear in the same cycle
        done_evt = 4'b0010;
        wr(1'b0, 8'h00);
        done_evt = '0;
        rd(1'b0, r); chk("R5 set beats clear", r, 8'h02);

        // R6 mask then re-enable
        wr(1'b0, 8'h00);
        done_evt = 4'b0100;
        tick();
        done_evt = '0;
        chk("R6 request before mask", irq_req, 8'h04);
        wr(1'b1, 8'hFB);
        chk("R6 masked request", irq_req, 8'h00);
        chk("R6 masked valid", {7'd0, irq_valid}, 8'h00);
        rd(1'b0, r); chk("R6 flag kept under mask", r, 8'h04);
        wr(1'b1, 8'hFF);
        chk("R6 re-enabled request", irq_req, 8'h04);
        chk("R7 re-enabled vector", {5'd0, irq_vec}, 8'h02);

        // R9 reset mid-run
        dst_ovf = 4'b0010;
        tick();
        dst_ovf = '0;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        rd(1'b0, r); chk("R9 flags after mid reset", r, 8'h00);
        rd(1'b1, r); chk("R9 enables after mid reset", r, 8'h00);
        chk("R9 requests after mid reset", irq_req, 8'h00);

        finish_run();
    end
endmodule